// File: doc/BRIEF.md
# Bitwise Logical Function Unit

The block applies one of eight bitwise Boolean operations to two operands of equal width and returns a result of that same width. A 3-bit operation code picks the operation. Two of the eight codes ignore the operands and return a constant: all ones or all zeros.

Each result bit is produced on its own from the matching operand bits. All eight candidate results are formed for that bit, and a one-hot select picks one of them. The select is decoded once from the operation code and shared by every bit.

The block has no clock and no state. A change on either operand or on the code reaches the result through combinational logic only. It suits a datapath slot where a cheap logic unit is needed and the caller chooses the function on each access.

Top module: `lfu_top`

## Requirements
- R1: Code 3'b000 drives every result bit to 1, whatever the operands. The code's bit 2 is the most significant selector bit and bit 0 the least.
- R2: Code 3'b111 drives every result bit to 0, whatever the operands.
- R3: Code 3'b001 yields the bitwise OR of the two operands.
- R4: Code 3'b010 yields the bitwise NAND of the two operands.
- R5: Code 3'b011 yields the bitwise XOR of the two operands.
- R6: Code 3'b100 yields the bitwise XNOR of the two operands.
- R7: Code 3'b101 yields the bitwise AND of the two operands.
- R8: Code 3'b110 yields the bitwise NOR of the two operands.
- R9: Result bit i depends only on operand bit i and the code. A single set bit in one operand, walked across all WIDTH positions, changes no other result bit.
- R10: The result follows a change on the operands or the code without any clock edge. It is valid within the same simulation time step as the input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation select; bit 2 is the most significant selector bit |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Bitwise result of the selected operation |

## Verification
An operand change and a code change can land in the same step, so the result must settle on the new operation applied to the new operands. The bench drives that case by changing the code and both operands in one assignment. It then compares the result against its own arithmetic model before any clock edge could matter. The constant codes are also judged under all-zero and all-one operands, which shows they ignore the operand values.

// File: rtl/lfu_pkg.sv
// Package: shared operation encoding for the logical function unit.
// Assumes: a 3-bit code whose numeric value is the operation index.
package lfu_pkg;
    localparam int LFU_CODE_W  = 3;
    localparam int LFU_NUM_OPS = 1 << LFU_CODE_W;

    typedef enum logic [LFU_CODE_W-1:0] {
        LFU_ONE  = 3'd0,
        LFU_OR   = 3'd1,
        LFU_NAND = 3'd2,
        LFU_XOR  = 3'd3,
        LFU_XNOR = 3'd4,
        LFU_AND  = 3'd5,
        LFU_NOR  = 3'd6,
        LFU_ZERO = 3'd7
    } lfu_op_e;
endpackage

// File: rtl/lfu_decode.sv
// Module: turns the operation code into a one-hot select shared by all bits.
// Assumes: the code is binary with bit 2 most significant; every code is legal.
module lfu_decode
    import lfu_pkg::*;
(
    input  logic [LFU_CODE_W-1:0]  code,
    output logic [LFU_NUM_OPS-1:0] sel_oh
);
    // Purpose: assert exactly one select line for the given code.
    always_comb begin
        for (int k = 0; k < LFU_NUM_OPS; k++) begin
            sel_oh[k] = (code == LFU_CODE_W'(k));
        end
    end

    // R1 R2 R3 R4 R5 R6 R7 R8
    always_comb begin
        sel_onehot_chk: assert ($onehot(sel_oh))
            else $display("sel_onehot_chk violated: %b", sel_oh);
    end
endmodule

// File: rtl/lfu_bit_cell.sv
// Module: one result bit; forms all eight candidates and picks one by select.
// Assumes: sel_oh is one-hot, ordered as the lfu_op_e encoding.
module lfu_bit_cell
    import lfu_pkg::*;
(
    input  logic                   a,
    input  logic                   b,
    input  logic [LFU_NUM_OPS-1:0] sel_oh,
    output logic                   y
);
    logic [LFU_NUM_OPS-1:0] cand;

    // Purpose: precompute every operation result for this bit.
    always_comb begin
        cand           = '0;
        cand[LFU_ONE]  = 1'b1;
        cand[LFU_OR]   = a | b;
        cand[LFU_NAND] = ~(a & b);
        cand[LFU_XOR]  = a ^ b;
        cand[LFU_XNOR] = ~(a ^ b);
        cand[LFU_AND]  = a & b;
        cand[LFU_NOR]  = ~(a | b);
        cand[LFU_ZERO] = 1'b0;
    end

    // Purpose: AND-OR selection of one candidate (an 8:1 mux).
    always_comb begin
        y = |(cand & sel_oh);
    end
endmodule

// File: rtl/lfu_top.sv
// Module: bitwise logical function unit; WIDTH identical bit cells share one decoder.
// Assumes: purely combinational use; no clock or reset is needed.
module lfu_top
    import lfu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [LFU_CODE_W-1:0] op_code,
    input  logic [WIDTH-1:0]      opnd_a,
    input  logic [WIDTH-1:0]      opnd_b,
    output logic [WIDTH-1:0]      result
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [LFU_NUM_OPS-1:0] sel_oh;

    lfu_decode u_dec (
        .code   (op_code),
        .sel_oh (sel_oh)
    );

    // One cell per result bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        lfu_bit_cell u_cell (
            .a      (opnd_a[i]),
            .b      (opnd_b[i]),
            .sel_oh (sel_oh),
            .y      (result[i])
        );
    end

    // Purpose: guard port-level relations of the selected operation.
    always_comb begin
        // R1
        if (op_code == LFU_ONE) begin
            all_ones_chk: assert (result == ALL_ONES)
                else $display("all_ones_chk violated: %h", result);
        end
        // R2
        if (op_code == LFU_ZERO) begin
            all_zero_chk: assert (result == '0)
                else $display("all_zero_chk violated: %h", result);
        end
        // R3
        if (op_code == LFU_OR) begin
            or_cover_chk: assert (((opnd_a | opnd_b) & ~result) == '0)
                else $display("or_cover_chk violated: %h", result);
        end
        // R7
        if (op_code == LFU_AND) begin
            and_subset_chk: assert ((result & ~opnd_a) == '0)
                else $display("and_subset_chk violated: %h", result);
        end
        // R8
        if (op_code == LFU_NOR) begin
            nor_disjoint_chk: assert ((result & (opnd_a | opnd_b)) == '0)
                else $display("nor_disjoint_chk violated: %h", result);
        end
    end
endmodule

// File: tb/tb_lfu_top.sv
module tb_lfu_top;
    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic [2:0]       op_code;
    logic [WIDTH-1:0] opnd_a, opnd_b;
    logic [WIDTH-1:0] result;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lfu_top #(.WIDTH(WIDTH)) dut (
        .op_code (op_code),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .result  (result)
    );

    function automatic logic [WIDTH-1:0] model(input logic [2:0] c,
                                               input logic [WIDTH-1:0] a,
                                               input logic [WIDTH-1:0] b);
        case (c)
            3'd0: return {WIDTH{1'b1}};
            3'd1: return a | b;
            3'd2: return ~(a & b);
            3'd3: return a ^ b;
            3'd4: return ~(a ^ b);
            3'd5: return a & b;
            3'd6: return ~(a | b);
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd0: return "R1";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R2";
        endcase
    endfunction

    // Drive all inputs at once, sample after a short settle, away from clock edges.
    task automatic apply_check(input logic [2:0] c, input logic [WIDTH-1:0] a,
                               input logic [WIDTH-1:0] b, input string req);
        logic [WIDTH-1:0] exp;
        @(negedge clk);
        op_code = c; opnd_a = a; opnd_b = b;
        #1;
        exp = model(c, a, b);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s code=%0d a=%h b=%h: actual %h expected %h",
                     req, c, a, b, result, exp);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        op_code = 3'd0; opnd_a = '0; opnd_b = '0;
        // Initial state: R1 with zero operands.
        apply_check(3'd0, '0, '0, "R1");
        for (int c = 0; c < 8; c++) begin
            // Patterns with all-zero and all-one operands (R1/R2 ignore operands).
            apply_check(3'(c), '0, '0, req_of(3'(c)));
            apply_check(3'(c), '1, '1, req_of(3'(c)));
            apply_check(3'(c), '1, '0, req_of(3'(c)));
            apply_check(3'(c), '0, '1, req_of(3'(c)));
            for (int n = 0; n < 40; n++) begin
                apply_check(3'(c), WIDTH'($urandom), WIDTH'($urandom), req_of(3'(c)));
            end
        end
        // R9: walk a single one in each operand; other bits must follow zero operands.
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < WIDTH; i++) begin
                apply_check(3'(c), WIDTH'(1) << i, '0, "R9");
                apply_check(3'(c), '0, WIDTH'(1) << i, "R9");
            end
        end
        // R10: code and operands change in the same step, checked without any edge in between.
        for (int n = 0; n < 64; n++) begin
            apply_check(3'($urandom), WIDTH'($urandom), WIDTH'($urandom), "R10");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule